// File: doc/BRIEF.md
# Interrupt Blocking State Tracker

This block keeps the record of every condition that currently stops a processor core from accepting a maskable interrupt, a non-maskable interrupt (NMI) or a system-management interrupt (SMI). Some conditions are one-instruction shadows: after an STI that turns interrupts on, or after a load of the stack segment, the core must let one more instruction complete before it takes a maskable interrupt. Others are long-lived. NMIs stay blocked from an NMI or SMI delivery until the next IRET. SMIs stay blocked for as long as the core is in system-management mode (SMM).

The core reports each relevant event as a one-cycle pulse. The block turns these pulses into four state flags and from them derives three blocking outputs that the interrupt arbiter uses. The flags are packed into a 32-bit word that a context switch can save. The same word can be written back through a restore port. A combinational flag states whether the offered word is legal, and an illegal word is never loaded. A virtual-NMI mode input changes the meaning of the NMI flag: it then records guest readiness and no longer blocks real NMIs.

A retirement pulse marks the completion of any instruction other than the one that raised a shadow. The STI and stack-load pulses stand in for the retirement of those instructions.

Top module: `intr_block_tracker`

## Requirements
- R1: After reset the state word is zero, so all four flags are clear.
- R2: An STI pulse with `sti_prev_if_i` = 0 sets bit 0 of the state word on the next cycle. The next `retire_i` pulse clears it. An STI pulse with `sti_prev_if_i` = 1 leaves bit 0 unchanged.
- R3: A stack-segment load pulse sets bit 1 on the next cycle, and the next `retire_i` pulse clears it. If a load pulse and a retirement arrive in the same cycle, bit 1 is set.
- R4: `smm_enter_i` sets bit 2 and `smm_exit_i` clears it. `smi_blocked_o` equals bit 2.
- R5: An NMI delivery or an SMI delivery sets bit 3, and an IRET clears it. A delivery in the same cycle as an IRET leaves bit 3 set.
- R6: When `vnmi_mode_i` is 1, bit 3 still sets and clears as in R5 but no longer drives `nmi_blocked_o`.
- R7: `restore_ok_o` is 1 exactly when bits 31:4 of `restore_word_i` are all zero. Bits 31:4 of `state_word_o` always read zero.
- R8: A `restore_i` pulse with a legal word loads bits 3:0 from that word on the next cycle. It takes priority over any event pulse in the same cycle. A restore pulse with an illegal word leaves the state unchanged.
- R9: `intr_blocked_o` = bit 0 OR bit 1 OR (NOT `if_flag_i`).
- R10: `nmi_blocked_o` = (bit 3 AND NOT `vnmi_mode_i`) OR bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | Pulse: an instruction retired |
| sti_i | input | 1 | Pulse: STI executed |
| sti_prev_if_i | input | 1 | Interrupt-enable flag value before that STI |
| ss_load_i | input | 1 | Pulse: MOV or POP to the stack segment executed |
| nmi_deliver_i | input | 1 | Pulse: NMI delivered |
| smi_deliver_i | input | 1 | Pulse: SMI delivered |
| iret_i | input | 1 | Pulse: IRET executed |
| smm_enter_i | input | 1 | Pulse: system-management mode entered |
| smm_exit_i | input | 1 | Pulse: system-management mode left |
| vnmi_mode_i | input | 1 | Virtual-NMI mode enabled |
| if_flag_i | input | 1 | Current interrupt-enable flag |
| restore_i | input | 1 | Pulse: load the state from `restore_word_i` |
| restore_word_i | input | 32 | Saved state word offered for restore |
| restore_ok_o | output | 1 | Offered word is legal (bits 31:4 zero) |
| state_word_o | output | 32 | Packed state: bit0 STI, bit1 stack load, bit2 SMI, bit3 NMI |
| intr_blocked_o | output | 1 | Maskable interrupts blocked |
| nmi_blocked_o | output | 1 | Real NMIs blocked |
| smi_blocked_o | output | 1 | SMIs blocked |

## Verification
The bench checks that a shadow lasts exactly one retirement. A design that cleared too early would open the window at once, and one that never cleared would lock interrupts out. It also checks that an STI issued while interrupts were already enabled raises no shadow. It covers the cycle in which a set and a clear arrive together, where reversed priority would drop an NMI block on the IRET cycle. The restore path is tested with a legal word and with a word that has one reserved bit set. A design that checked the wrong bits would either corrupt the state or refuse a legal restore. Virtual-NMI mode is tested with the core in and out of SMM, because a design that masked the whole NMI output in that mode would let NMIs through during SMM.

// File: rtl/intr_blk_pkg.sv
package intr_blk_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned FLAG_STI  = 0;
  localparam int unsigned FLAG_SS   = 1;
  localparam int unsigned FLAG_SMI  = 2;
  localparam int unsigned FLAG_NMI  = 3;

  // A word is legal when every bit above the flag field is zero.
  function automatic logic word_is_legal(input logic [31:0] w);
    return (w >> NUM_FLAGS) == 32'd0;
  endfunction

  // Zero-extend the flag field into a full state word.
  function automatic logic [31:0] pack_flags(input logic [NUM_FLAGS-1:0] f);
    logic [31:0] w;
    w = '0;
    w[NUM_FLAGS-1:0] = f;
    return w;
  endfunction

  function automatic logic maskable_blocked(input logic [NUM_FLAGS-1:0] f,
                                            input logic if_flag);
    return f[FLAG_STI] | f[FLAG_SS] | ~if_flag;
  endfunction

  function automatic logic nmi_gate(input logic [NUM_FLAGS-1:0] f,
                                    input logic vnmi);
    return (f[FLAG_NMI] & ~vnmi) | f[FLAG_SMI];
  endfunction
endpackage

// File: rtl/blk_flag.sv
// One state flag: restore has top priority, then set, then clear.
module blk_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic load_i,
  input  logic load_val_i,
  output logic q_o
);
  logic q_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       q_q <= 1'b0;
    else if (load_i)  q_q <= load_val_i;
    else if (set_i)   q_q <= 1'b1;
    else if (clr_i)   q_q <= 1'b0;
  end
  assign q_o = q_q;
endmodule

// File: rtl/word_check.sv
module word_check #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              req_i,
  output logic              legal_o,
  output logic              take_o
);
  import intr_blk_pkg::*;
  logic [31:0] w32;
  always_comb begin
    w32 = '0;
    w32[WORD_W-1:0] = word_i;
  end
  assign legal_o = word_is_legal(w32);
  assign take_o  = req_i & legal_o;
endmodule

// File: rtl/intr_block_tracker.sv
module intr_block_tracker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        retire_i,
  input  logic        sti_i,
  input  logic        sti_prev_if_i,
  input  logic        ss_load_i,
  input  logic        nmi_deliver_i,
  input  logic        smi_deliver_i,
  input  logic        iret_i,
  input  logic        smm_enter_i,
  input  logic        smm_exit_i,
  input  logic        vnmi_mode_i,
  input  logic        if_flag_i,
  input  logic        restore_i,
  input  logic [31:0] restore_word_i,
  output logic        restore_ok_o,
  output logic [31:0] state_word_o,
  output logic        intr_blocked_o,
  output logic        nmi_blocked_o,
  output logic        smi_blocked_o
);
  import intr_blk_pkg::*;

  // Named event wires, also used by the checker.
  logic                 sti_shadow_ev;
  logic                 take_restore;
  logic [NUM_FLAGS-1:0] set_v, clr_v, flags;

  assign sti_shadow_ev = sti_i & ~sti_prev_if_i;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[FLAG_STI] = sti_shadow_ev;
    clr_v[FLAG_STI] = retire_i;
    set_v[FLAG_SS]  = ss_load_i;
    clr_v[FLAG_SS]  = retire_i;
    set_v[FLAG_SMI] = smm_enter_i;
    clr_v[FLAG_SMI] = smm_exit_i;
    set_v[FLAG_NMI] = nmi_deliver_i | smi_deliver_i;
    clr_v[FLAG_NMI] = iret_i;
  end

  word_check #(.WORD_W(32)) u_check (
    .word_i  (restore_word_i),
    .req_i   (restore_i),
    .legal_o (restore_ok_o),
    .take_o  (take_restore)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    blk_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_v[g]),
      .clr_i      (clr_v[g]),
      .load_i     (take_restore),
      .load_val_i (restore_word_i[g]),
      .q_o        (flags[g])
    );
  end

  assign state_word_o   = pack_flags(flags);
  assign intr_blocked_o = maskable_blocked(flags, if_flag_i);
  assign nmi_blocked_o  = nmi_gate(flags, vnmi_mode_i);
  assign smi_blocked_o  = flags[FLAG_SMI];
endmodule

// File: rtl/intr_block_tracker_chk.sv
module intr_block_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        retire_i,
  input logic        sti_shadow_ev,
  input logic        ss_load_i,
  input logic        nmi_deliver_i,
  input logic        smi_deliver_i,
  input logic        iret_i,
  input logic        smm_enter_i,
  input logic        smm_exit_i,
  input logic        vnmi_mode_i,
  input logic        restore_i,
  input logic        restore_ok_o,
  input logic        take_restore,
  input logic [31:0] state_word_o,
  input logic        nmi_blocked_o,
  input logic        smi_blocked_o
);
  logic any_ev;
  assign any_ev = retire_i | sti_shadow_ev | ss_load_i | nmi_deliver_i |
                  smi_deliver_i | iret_i | smm_enter_i | smm_exit_i;

  a_r2_sti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sti_shadow_ev && !restore_i |=> state_word_o[0]);

  a_r3_ss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    state_word_o[1] && retire_i && !ss_load_i && !restore_i |=> !state_word_o[1]);

  a_r4_smm_blocks_smi: assert property (@(posedge clk) disable iff (!rst_n)
    smm_enter_i && !restore_i |=> smi_blocked_o && nmi_blocked_o);

  a_r5_nmi_held: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_deliver_i || smi_deliver_i) && !restore_i |=> state_word_o[3]);

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_word_o[31:4] == 28'd0);

  a_r8_bad_restore_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i && !restore_ok_o && !any_ev |=> $stable(state_word_o));

  a_r8_take_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    take_restore |-> restore_ok_o);

  a_r10_vnmi_smm: assert property (@(posedge clk) disable iff (!rst_n)
    vnmi_mode_i && !state_word_o[2] |-> !nmi_blocked_o);
endmodule

bind intr_block_tracker intr_block_tracker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .retire_i      (retire_i),
  .sti_shadow_ev (sti_shadow_ev),
  .ss_load_i     (ss_load_i),
  .nmi_deliver_i (nmi_deliver_i),
  .smi_deliver_i (smi_deliver_i),
  .iret_i        (iret_i),
  .smm_enter_i   (smm_enter_i),
  .smm_exit_i    (smm_exit_i),
  .vnmi_mode_i   (vnmi_mode_i),
  .restore_i     (restore_i),
  .restore_ok_o  (restore_ok_o),
  .take_restore  (take_restore),
  .state_word_o  (state_word_o),
  .nmi_blocked_o (nmi_blocked_o),
  .smi_blocked_o (smi_blocked_o)
);

// File: tb/intr_block_tracker_bench.sv
module intr_block_tracker_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire_i = 0, sti_i = 0, sti_prev_if_i = 0, ss_load_i = 0;
  logic nmi_deliver_i = 0, smi_deliver_i = 0, iret_i = 0;
  logic smm_enter_i = 0, smm_exit_i = 0, vnmi_mode_i = 0, if_flag_i = 1;
  logic restore_i = 0;
  logic [31:0] restore_word_i = '0;
  logic        restore_ok_o, intr_blocked_o, nmi_blocked_o, smi_blocked_o;
  logic [31:0] state_word_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  intr_block_tracker u_intr_block_tracker (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Pulses were set after a negedge; let one posedge capture them, then clear.
  task automatic cycle();
    @(negedge clk);
    retire_i = 0; sti_i = 0; ss_load_i = 0; nmi_deliver_i = 0;
    smi_deliver_i = 0; iret_i = 0; smm_enter_i = 0; smm_exit_i = 0;
    restore_i = 0;
    #0.5;
  endtask

  task automatic t_reset();
    chk_eq("R1 word after reset", state_word_o, 32'h0);
    chk_eq("R9 intr with IF=1", {31'd0, intr_blocked_o}, 32'd0);
    if_flag_i = 0; #0.5;
    chk_eq("R9 intr with IF=0", {31'd0, intr_blocked_o}, 32'd1);
    if_flag_i = 1; #0.5;
  endtask

  task automatic t_sti();
    sti_i = 1; sti_prev_if_i = 0; cycle();
    chk_eq("R2 STI shadow set", state_word_o, 32'h1);
    chk_eq("R9 blocked by STI shadow", {31'd0, intr_blocked_o}, 32'd1);
    cycle();
    chk_eq("R2 shadow held without retire", state_word_o, 32'h1);
    retire_i = 1; cycle();
    chk_eq("R2 shadow cleared by retire", state_word_o, 32'h0);
    sti_i = 1; sti_prev_if_i = 1; cycle();
    chk_eq("R2 STI with IF=1 no shadow", state_word_o, 32'h0);
  endtask

  task automatic t_ss();
    ss_load_i = 1; retire_i = 1; cycle();
    chk_eq("R3 SS shadow set over retire", state_word_o, 32'h2);
    chk_eq("R9 blocked by SS shadow", {31'd0, intr_blocked_o}, 32'd1);
    retire_i = 1; cycle();
    chk_eq("R3 SS shadow cleared", state_word_o, 32'h0);
  endtask

  task automatic t_smm();
    smm_enter_i = 1; cycle();
    chk_eq("R4 SMM sets bit2", state_word_o, 32'h4);
    chk_eq("R4 smi blocked", {31'd0, smi_blocked_o}, 32'd1);
    chk_eq("R10 nmi blocked in SMM", {31'd0, nmi_blocked_o}, 32'd1);
    vnmi_mode_i = 1; #0.5;
    chk_eq("R10 nmi blocked in SMM with vnmi", {31'd0, nmi_blocked_o}, 32'd1);
    vnmi_mode_i = 0;
    smm_exit_i = 1; cycle();
    chk_eq("R4 SMM exit clears", state_word_o, 32'h0);
    chk_eq("R4 smi unblocked", {31'd0, smi_blocked_o}, 32'd0);
  endtask

  task automatic t_nmi();
    nmi_deliver_i = 1; cycle();
    chk_eq("R5 NMI sets bit3", state_word_o, 32'h8);
    chk_eq("R10 nmi blocked", {31'd0, nmi_blocked_o}, 32'd1);
    iret_i = 1; smi_deliver_i = 1; cycle();
    chk_eq("R5 delivery beats IRET", state_word_o, 32'h8);
    iret_i = 1; cycle();
    chk_eq("R5 IRET clears", state_word_o, 32'h0);
    smi_deliver_i = 1; cycle();
    chk_eq("R5 SMI delivery sets bit3", state_word_o, 32'h8);
    vnmi_mode_i = 1; #0.5;
    chk_eq("R6 vnmi frees real NMI", {31'd0, nmi_blocked_o}, 32'd0);
    iret_i = 1; cycle();
    chk_eq("R6 bit3 still clears in vnmi", state_word_o, 32'h0);
    nmi_deliver_i = 1; cycle();
    chk_eq("R6 bit3 still sets in vnmi", state_word_o, 32'h8);
    iret_i = 1; cycle();
    vnmi_mode_i = 0; #0.5;
  endtask

  task automatic t_restore();
    restore_word_i = 32'h0000_000D; #0.5;
    chk_eq("R7 legal word ok", {31'd0, restore_ok_o}, 32'd1);
    restore_i = 1; nmi_deliver_i = 1; cycle();
    chk_eq("R8 restore loads and beats event", state_word_o, 32'hD);
    restore_word_i = 32'h0000_0012; #0.5;
    chk_eq("R7 bit4 set is illegal", {31'd0, restore_ok_o}, 32'd0);
    restore_i = 1; cycle();
    chk_eq("R8 illegal restore ignored", state_word_o, 32'hD);
    restore_word_i = 32'h8000_0000; #0.5;
    chk_eq("R7 bit31 set is illegal", {31'd0, restore_ok_o}, 32'd0);
    restore_word_i = 32'h0; restore_i = 1; cycle();
    chk_eq("R8 restore zero", state_word_o, 32'h0);
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #0.5;
    t_reset();
    t_sti();
    t_ss();
    t_smm();
    t_nmi();
    t_restore();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule